// File: doc/BRIEF.md
# SCL Stretch Timeout Watchdog

This block supervises a released clock line of a two-wire serial bus while a slave may still be holding it low. When the bus engine has let go of the clock and needs to know whether the line really rose, it strobes `start_i`. The watchdog then runs a wait with two phases. In the first phase it examines the synchronized clock level on every system clock cycle for a short spin window. If that window ends with the line still low, the watchdog falls back to coarse polling: it looks at the line once per poll interval and emits a stretch pulse whenever a poll finds it still low.

The wait ends with success as soon as a permitted check sees the line high. It ends with a timeout once a programmable overall deadline, counted from the start strobe, has passed. All time is measured in ticks of an external microsecond timebase, so the block does not depend on the system clock frequency. The spin window and the poll interval are parameters. The deadline is an input, and a value of zero selects a parameterized default of 25,000 microseconds. Driving the bus pins is left to the surrounding engine.

Top module: `scl_stretch_guard`

## Requirements
- R1: After reset, `done_o`, `ok_o`, `timeout_o` and `stretch_o` are all 0 and the block is idle, ready to accept `start_i`.
- R2: From the first cycle after an accepted start, during the spin phase `scl_i` is sampled on every clock edge. The first edge that samples it high ends the wait, and one clock later `done_o`=1 and `ok_o`=1. At the same edge this outcome takes priority over a deadline tick.
- R3: The spin phase lasts exactly SPIN_US ticks of `us_tick_i` after the start. No `stretch_o` pulse occurs during it.
- R4: After the spin phase, `scl_i` is examined only on the tick that completes each POLL_US-tick interval, that is on ticks SPIN_US + k*POLL_US for k ≥ 1. A high level on any other cycle of this phase has no effect.
- R5: Each poll check that finds `scl_i` low produces a one-cycle `stretch_o` pulse one clock later. This includes a check that falls on the deadline tick.
- R6: The deadline is captured from `limit_i` when a start is accepted, and later changes of `limit_i` are ignored. On tick number L counted from the start, the wait ends with `done_o`=1, `ok_o`=0 and `timeout_o`=1 one clock later, unless a check permitted at that same edge finds `scl_i` high.
- R7: When the deadline is no later than SPIN_US ticks, the wait times out at the deadline without any poll check and without any `stretch_o` pulse.
- R8: `limit_i` = 0 selects DEFAULT_LIMIT_US ticks as the deadline.
- R9: A `start_i` strobe while a wait is active is ignored. It neither restarts the deadline nor the phase timing.
- R10: `done_o` is a single-cycle pulse. `ok_o` and `timeout_o` are high only together with `done_o`, and exactly one of them accompanies each `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe that requests a new wait |
| scl_i | input | 1 | Synchronized clock-line level, 1 = high |
| us_tick_i | input | 1 | One-cycle pulse per microsecond of timebase |
| limit_i | input | LIMIT_W | Overall deadline in ticks, 0 selects the default |
| done_o | output | 1 | One-cycle pulse when the wait ends |
| ok_o | output | 1 | With `done_o`: the line was seen high |
| timeout_o | output | 1 | With `done_o`: the deadline expired |
| stretch_o | output | 1 | One-cycle pulse per poll that still found the line low |

## Verification
Every result is registered. `done_o`, `ok_o`, `timeout_o` and `stretch_o` therefore appear exactly one clock after the edge that samples the deciding tick or line level, and an accepted start affects nothing before the following edge. The bench drives all inputs on the falling edge and reads the outputs on the next falling edge. It keeps a tally of the ticks it has driven, and compares that tally at the moment `done_o` is seen against the tick number at which a bench function predicts the wait must end. The same function also predicts the outcome and the number of stretch pulses for each combination of deadline, release tick and tick spacing.

// File: rtl/stretch_guard_pkg.sv
package stretch_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SPIN = 2'd1,
        ST_POLL = 2'd2
    } guard_state_e;

    typedef struct packed {
        guard_state_e state;
        logic         done;
        logic         ok;
        logic         timeout;
        logic         stretch;
    } guard_regs_t;

endpackage

// File: rtl/sg_deadline.sv
module sg_deadline #(
    parameter int LIMIT_W          = 16,
    parameter int DEFAULT_LIMIT_US = 25000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               run_i,
    input  logic               tick_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               hit_o
);
    localparam logic [LIMIT_W-1:0] DEF_LIMIT = LIMIT_W'(DEFAULT_LIMIT_US);

    typedef struct packed {
        logic [LIMIT_W-1:0] elapsed;
        logic [LIMIT_W-1:0] limit;
    } dl_regs_t;

    dl_regs_t r_d, r_q;
    logic [LIMIT_W:0] next_count;

    always_comb begin
        next_count = {1'b0, r_q.elapsed} + {{LIMIT_W{1'b0}}, 1'b1};
        hit_o      = run_i && tick_i && (next_count >= {1'b0, r_q.limit});
    end

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.elapsed = '0;
            r_d.limit   = (limit_i == '0) ? DEF_LIMIT : limit_i;
        end else if (run_i && tick_i) begin
            r_d.elapsed = next_count[LIMIT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R6: while a wait runs the elapsed count never reaches the deadline
    p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (r_q.elapsed < r_q.limit));

endmodule

// File: rtl/sg_interval.sv
module sg_interval #(
    parameter int SPIN_US = 1000,
    parameter int POLL_US = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    input  logic poll_i,
    input  logic tick_i,
    output logic end_o
);
    localparam int MAX_IV = (SPIN_US > POLL_US) ? SPIN_US : POLL_US;
    localparam int CW     = $clog2(MAX_IV + 1);
    localparam logic [CW:0] SPIN_T = (CW+1)'(SPIN_US);
    localparam logic [CW:0] POLL_T = (CW+1)'(POLL_US);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   target;
    logic [CW:0]   cnt_inc;

    always_comb begin
        target  = poll_i ? POLL_T : SPIN_T;
        cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
        end_o   = run_i && tick_i && (cnt_inc == target);
    end

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                 cnt_d = '0;
        else if (end_o)             cnt_d = '0;
        else if (run_i && tick_i)   cnt_d = cnt_inc[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the interval counter stays below the interval it is timing
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> ({1'b0, cnt_q} < target));

endmodule

// File: rtl/scl_stretch_guard.sv
module scl_stretch_guard
    import stretch_guard_pkg::*;
#(
    parameter int SPIN_US          = 1000,
    parameter int POLL_US          = 1000,
    parameter int LIMIT_W          = 16,
    parameter int DEFAULT_LIMIT_US = 25000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               scl_i,
    input  logic               us_tick_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               done_o,
    output logic               ok_o,
    output logic               timeout_o,
    output logic               stretch_o
);
    guard_regs_t r_d, r_q;
    logic accept, running, polling, dl_hit, iv_end;

    always_comb begin
        accept  = (r_q.state == ST_IDLE) && start_i;
        running = (r_q.state != ST_IDLE);
        polling = (r_q.state == ST_POLL);
    end

    sg_deadline #(
        .LIMIT_W          (LIMIT_W),
        .DEFAULT_LIMIT_US (DEFAULT_LIMIT_US)
    ) u_deadline (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .run_i   (running),
        .tick_i  (us_tick_i),
        .limit_i (limit_i),
        .hit_o   (dl_hit)
    );

    sg_interval #(
        .SPIN_US (SPIN_US),
        .POLL_US (POLL_US)
    ) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .run_i  (running),
        .poll_i (polling),
        .tick_i (us_tick_i),
        .end_o  (iv_end)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.ok      = 1'b0;
        r_d.timeout = 1'b0;
        r_d.stretch = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (accept) r_d.state = ST_SPIN;
            end
            ST_SPIN: begin
                if (scl_i) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.ok    = 1'b1;
                end else if (dl_hit) begin
                    r_d.state   = ST_IDLE;
                    r_d.done    = 1'b1;
                    r_d.timeout = 1'b1;
                end else if (iv_end) begin
                    r_d.state = ST_POLL;
                end
            end
            ST_POLL: begin
                if (iv_end && scl_i) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.ok    = 1'b1;
                end else begin
                    if (iv_end) r_d.stretch = 1'b1;
                    if (dl_hit) begin
                        r_d.state   = ST_IDLE;
                        r_d.done    = 1'b1;
                        r_d.timeout = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o    = r_q.done;
    assign ok_o      = r_q.ok;
    assign timeout_o = r_q.timeout;
    assign stretch_o = r_q.stretch;

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10: status flags only accompany done, never both
    p_ok_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> (done_o && !timeout_o));
    p_to_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (done_o && !ok_o));
    p_done_has_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ok_o || timeout_o));
    // R2: success is only reported after the line was sampled high
    p_ok_saw_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> $past(scl_i));
    // R5: a stretch pulse follows a low sample on a tick
    p_stretch_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_o |-> (!$past(scl_i) && $past(us_tick_i)));
    // R6: a timeout only follows a timebase tick
    p_to_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> $past(us_tick_i));

endmodule

// File: tb/scl_stretch_guard_test.sv
`timescale 1ns/1ps
module scl_stretch_guard_test;
    localparam int SPIN  = 6;
    localparam int POLL  = 4;
    localparam int LW    = 8;
    localparam int DEFL  = 30;
    localparam int NEVER = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic scl_i = 1'b0;
    logic us_tick_i = 1'b0;
    logic [LW-1:0] limit_i = '0;
    logic done_o, ok_o, timeout_o, stretch_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    scl_stretch_guard #(
        .SPIN_US (SPIN), .POLL_US (POLL), .LIMIT_W (LW), .DEFAULT_LIMIT_US (DEFL)
    ) uut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .scl_i (scl_i),
        .us_tick_i (us_tick_i), .limit_i (limit_i), .done_o (done_o),
        .ok_o (ok_o), .timeout_o (timeout_o), .stretch_o (stretch_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected outcome from the requirements: release tick rel means scl_i
    // is high from the edge that samples tick rel onward (0 = before any tick).
    function automatic void predict(input int lim, input int rel,
                                    output int ok, output int end_t, output int nstr);
        int eff;
        int bnd;
        eff = (lim == 0) ? DEFL : lim;
        nstr = 0;
        if (rel <= ((SPIN < eff) ? SPIN : eff)) begin
            ok = 1; end_t = rel; return;
        end
        if (eff <= SPIN) begin
            ok = 0; end_t = eff; return;
        end
        for (int j = 1; SPIN + j * POLL <= eff; j++) begin
            bnd = SPIN + j * POLL;
            if (bnd >= rel) begin
                ok = 1; end_t = bnd; nstr = j - 1; return;
            end
            nstr = j;
        end
        ok = 0; end_t = eff;
    endfunction

    task automatic run_case(input int lim, input int rel, input int tp,
                            input bit xs, input bit glitch, input string tag);
        int ticks = 0, cyc = 0, strs = 0, phase = 0;
        int e_ok, e_end, e_str;
        bit seen = 0, hold, tick_now, xs_done = 0, gl_done = 0, gl_now;
        int got_ok = 0, got_to = 0, got_end = 0;
        predict(lim, rel, e_ok, e_end, e_str);
        @(negedge clk);
        start_i = 1'b1;
        limit_i = LW'(lim);
        hold = (rel == 0);
        scl_i = hold;
        us_tick_i = 1'b0;
        while (cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (stretch_o) strs++;
            if (done_o) begin
                seen = 1; got_ok = ok_o; got_to = timeout_o; got_end = ticks;
                break;
            end
            start_i = 1'b0;
            limit_i = LW'($urandom);  // R6: ignored after capture
            phase++;
            tick_now = (phase == tp);
            if (tick_now) begin
                phase = 0;
                ticks++;
                if (ticks == rel) hold = 1'b1;
            end
            us_tick_i = tick_now;
            if (xs && !xs_done && ticks == 2 && !tick_now) begin
                start_i = 1'b1;
                xs_done = 1;
            end
            gl_now = glitch && !gl_done && !hold && ticks == SPIN + 1 && !tick_now;
            if (gl_now) gl_done = 1;
            scl_i = hold | gl_now;
        end
        start_i = 1'b0;
        us_tick_i = 1'b0;
        chk({tag, " R10 done seen"}, int'(seen), 1);
        chk({tag, " R2 R4 status ok"}, got_ok, e_ok);
        chk({tag, " R6 timeout flag"}, got_to, 1 - e_ok);
        chk({tag, " R3 R6 R7 end tick"}, got_end, e_end);
        chk({tag, " R5 stretch count"}, strs, e_str);
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, int'(done_o), 0);
        scl_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", int'(done_o), 0);
        chk("R1 ok after reset", int'(ok_o), 0);
        chk("R1 timeout after reset", int'(timeout_o), 0);
        chk("R1 stretch after reset", int'(stretch_o), 0);

        run_case(20, 0, 2, 0, 0, "R2 immediate high");
        run_case(20, 3, 3, 0, 0, "R2 mid spin");
        run_case(20, SPIN, 2, 0, 0, "R3 last spin tick");
        run_case(20, SPIN + 1, 2, 0, 0, "R4 first poll waits");
        run_case(SPIN, NEVER, 2, 0, 0, "R7 deadline equals spin");
        run_case(SPIN, SPIN, 3, 0, 0, "R2 high at deadline in spin");
        run_case(1, NEVER, 2, 0, 0, "R7 one tick deadline");
        run_case(SPIN + 2 * POLL, SPIN + 2 * POLL, 2, 0, 0, "R6 boundary high at deadline");
        run_case(SPIN + 2 * POLL, NEVER, 2, 0, 0, "R5 stretch at deadline");
        run_case(0, NEVER, 2, 0, 0, "R8 default deadline");
        run_case(25, 17, 2, 0, 1, "R4 glitch ignored");
        run_case(22, NEVER, 3, 1, 0, "R9 restart ignored");
        run_case(23, 13, 4, 1, 1, "R9 R4 combined");

        for (int k = 0; k < 40; k++) begin
            int lim, rel, tp;
            lim = $urandom_range(0, 50);
            rel = ($urandom_range(0, 3) == 0) ? NEVER : $urandom_range(0, 50);
            tp  = $urandom_range(2, 4);
            run_case(lim, rel, tp, 1'($urandom), 1'($urandom), "rand");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule